// File: doc/BRIEF.md
# Flash programming sequencer with sector erase

This block programs a run of 32-bit words into a serial flash device. It reaches the device only through a pair of registers: an address register that carries a completion flag, and a data register. It first identifies the device, then picks the sector size and the location of the erase command from the manufacturer code. It raises the flash write enable and clears write protection, then walks the target addresses in order. Whenever an address is the first word of a sector, it issues an erase of that sector before it programs the word.

Each step that waits on the device polls the flag a bounded number of times. A program or erase that never completes ends the run. A failed identification read does not end the run: the sequencer falls back to a fixed identification word. On every exit the write enable is dropped, and a one-cycle done pulse reports the outcome and the word index reached.

The words to program come from an outside buffer. The sequencer presents an index and reads the word back in the same cycle. The register file is outside the block. Each access is a single-cycle strobe, and read data returns in the same cycle.

Top module: `flash_prog_seq`

## Requirements
- R1: After a start, the first bus write goes to the address register (bus_sel 0) with the word 0x000d03ab. Bit 31 is the completion flag, bit 30 selects configuration space, and the low ADDR_W bits hold the address; here both bit 31 and bit 30 are clear. The sequencer then reads the address register until bit 31 reads 1, and reads the data register (bus_sel 1). Bits 7:0 of that read are the manufacturer code and bits 15:8 are the device code.
- R2: If bit 31 is still 0 after RD_POLLS reads of the identification poll, the identification word is taken as 0xDEADDEAD and the run continues. Exactly RD_POLLS reads are issued in that poll.
- R3: For manufacturer code 0xbf, a sector boundary is an address whose low 13 bits (mask 0x1fff) are zero, and the sector mask is 0x3e000. The erase command goes to configuration address 0x352 when the device code is 0x80, and to 0x3d8 for any other device code.
- R4: For any other manufacturer code, including 0x13, a boundary is an address with mask 0x3fff clear, the sector mask is 0x3c000, and the erase command goes to configuration address 0x3d8.
- R5: At a boundary, the erase is a data-register write of s = (addr & sector mask) << 2, taken as 24 bits with bytes 0 and 2 exchanged. It is followed by an address-register write of 0xC0000000 | erase address.
- R6: Before any address is walked, flash_wen rises. The sequencer then writes 0 to the data register and 0xC0000101 to the address register, and polls until bit 31 clears or WR_POLLS reads have passed. Every address-register write with bit 31 set happens while flash_wen is 1.
- R7: Word i (from 0) is programmed from src_data while word_idx equals i. This is a data-register write of that word, then an address-register write of 0x80000000 | (base + i). Words go out in index order, and each word waits for bit 31 to read 0.
- R8: If bit 31 stays 1 for WR_POLLS reads after an erase, the run ends with status 1. After a program, the same ends the run with status 2. In both cases word_idx holds the failing index, no further bus write follows, and exactly WR_POLLS reads are issued in that poll.
- R9: done is high for exactly one cycle per run, and flash_wen is 0 in that cycle and afterwards. After a complete run, status is 0 and word_idx equals the word count; a count of 0 programs nothing.
- R10: base_addr and word_count are latched at start, and a start pulse during a run has no effect on the bus writes or the result.
- R11: In reset and in the first idle cycle after it, done, flash_wen, bus_wr and bus_rd are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle) |
| base_addr | input | ADDR_W | First flash word address |
| word_count | input | CNT_W | Number of words to program |
| src_data | input | 32 | Word to program at index word_idx |
| word_idx | output | CNT_W | Current word index; failing index or count at done |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_sel | output | 1 | 0 = address register, 1 = data register |
| bus_wdata | output | 32 | Register write data |
| bus_rdata | input | 32 | Register read data, same cycle |
| flash_wen | output | 1 | Flash write enable |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 2 | 0 ok, 1 erase timeout, 2 program timeout |

## Verification
In some cycles the end of one word's program and the sector-boundary test for the next address coincide. The step of the address counter must be visible to the boundary decision that follows it, or the erase lands one word late or never. Runs are started one or two words below a boundary, on a boundary at the very first word, and on addresses that are a boundary under one geometry but not the other. The bench compares every register write against an independently built list of expected writes, so a misplaced, missing or extra erase shows up as a mismatch. A second pairing is the identification timeout feeding the geometry choice: a silent identification read must still yield the default sector size.

// File: rtl/fps_pkg.sv
// Package: shared constants, state and status types for the flash
// programming sequencer. Assumes address widths of at most 24 bits.
package fps_pkg;

    localparam int unsigned FLAG_BIT = 31;
    localparam int unsigned CFG_BIT  = 30;

    localparam logic SEL_ADDR = 1'b0;
    localparam logic SEL_DATA = 1'b1;

    localparam logic [31:0] FLAG_MASK    = 32'h8000_0000;
    localparam logic [31:0] CFG_MASK     = 32'h4000_0000;
    localparam logic [31:0] ID_LOC       = 32'h000d_03ab;
    localparam logic [31:0] TIMEOUT_WORD = 32'hDEAD_DEAD;
    localparam logic [15:0] UNPROT_LOC   = 16'h0101;

    localparam logic [7:0]  SMALL_MFR     = 8'hbf;
    localparam logic [7:0]  ALT_DEV       = 8'h80;
    localparam logic [23:0] SMALL_OFF     = 24'h00_1fff;
    localparam logic [23:0] SMALL_SEC     = 24'h03_e000;
    localparam logic [23:0] BIG_OFF       = 24'h00_3fff;
    localparam logic [23:0] BIG_SEC       = 24'h03_c000;
    localparam logic [15:0] STD_ERASE_LOC = 16'h03d8;
    localparam logic [15:0] ALT_ERASE_LOC = 16'h0352;

    typedef enum logic [3:0] {
        S_IDLE, S_ID_AW, S_ID_POLL, S_ID_RD,
        S_UP_DW, S_UP_AW, S_UP_POLL, S_NEXT,
        S_ER_DW, S_ER_AW, S_ER_POLL,
        S_PG_DW, S_PG_AW, S_PG_POLL, S_DONE
    } fps_state_e;

    typedef enum logic [1:0] {
        ST_OK         = 2'd0,
        ST_ERASE_FAIL = 2'd1,
        ST_PROG_FAIL  = 2'd2
    } fps_status_e;

    typedef struct packed {
        logic [23:0] off_mask;
        logic [23:0] sec_mask;
        logic [15:0] erase_loc;
    } fps_geom_t;

    // Exchange the outer bytes of a 24-bit sector selector.
    function automatic logic [23:0] erase_word(input logic [23:0] s);
        return {s[7:0], s[15:8], s[23:16]};
    endfunction

endpackage

// File: rtl/fps_geom.sv
// Geometry decoder: maps manufacturer/device codes to the sector offset
// mask, sector mask and erase command location. Purely combinational;
// assumes the codes are stable while the walk runs.
module fps_geom
    import fps_pkg::*;
(
    input  logic [7:0] mfr_id,
    input  logic [7:0] dev_id,
    output fps_geom_t  geom
);

    // Select small or large sector layout from the codes.
    always_comb begin
        geom.off_mask  = BIG_OFF;
        geom.sec_mask  = BIG_SEC;
        geom.erase_loc = STD_ERASE_LOC;
        if (mfr_id == SMALL_MFR) begin
            geom.off_mask = SMALL_OFF;
            geom.sec_mask = SMALL_SEC;
            if (dev_id == ALT_DEV) begin
                geom.erase_loc = ALT_ERASE_LOC;
            end
        end
    end

endmodule

// File: rtl/fps_poll.sv
// Poll limiter: counts consecutive poll cycles while en is high and flags
// the last permitted one. Assumes the caller leaves the poll state on or
// before the cycle in which last is high.
module fps_poll #(
    parameter int unsigned PW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] limit,
    output logic          last
);

    logic [PW-1:0] cnt_q;

    // Count polls in the current wait, restart when the wait ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = en && (cnt_q == limit - 1'b1);

    p_poll_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt_q < limit));

endmodule

// File: rtl/fps_walk.sv
// Address walker: latches the start address and word count, steps the
// address and index together, and reports when the index reaches the
// count. Assumes step is never raised when at_end is high.
module fps_walk #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  idx,
    output logic              at_end
);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  cnt_q;

    // Latch the run on load, advance one word on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            idx_q  <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            addr_q <= base;
            idx_q  <= '0;
            cnt_q  <= count;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign cur_addr = addr_q;
    assign idx      = idx_q;
    assign at_end   = (idx_q == cnt_q);

    p_idx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= cnt_q);

    p_count_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cnt_q));

endmodule

// File: rtl/flash_prog_seq.sv
// Flash programming sequencer top: identifies the device, picks the sector
// geometry, unprotects, then erases at sector starts and programs each
// word through an address/data register pair with a completion flag.
// Assumes single-cycle register access with same-cycle read data and
// ADDR_W of at most 24.
module flash_prog_seq
    import fps_pkg::*;
#(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned RD_POLLS = 3000,
    parameter int unsigned WR_POLLS = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  word_count,
    input  logic [31:0]       src_data,
    output logic [CNT_W-1:0]  word_idx,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic              bus_sel,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    output logic              flash_wen,
    output logic              done,
    output logic [1:0]        status
);

    localparam int unsigned MAX_POLLS = (RD_POLLS > WR_POLLS) ? RD_POLLS : WR_POLLS;
    localparam int unsigned PW        = $clog2(MAX_POLLS + 1);
    localparam logic [PW-1:0] RD_LIM  = PW'(RD_POLLS);
    localparam logic [PW-1:0] WR_LIM  = PW'(WR_POLLS);

    fps_state_e        st_q, st_d;
    fps_status_e       status_q, fin_st;
    fps_geom_t         geom;
    logic [15:0]       id_q;
    logic              wen_q;
    logic [ADDR_W-1:0] cur_addr;
    logic              at_end;
    logic              poll_en, poll_last;
    logic [PW-1:0]     poll_limit;
    logic              walk_load, walk_step;
    logic              id_cap, id_to, fin;
    logic              flag_in;
    logic [23:0]       ext_addr, sec_sel;
    logic              on_boundary;
    logic [31:0]       erase_payload;
    logic              unused_rd_bits;

    assign flag_in        = bus_rdata[FLAG_BIT];
    assign unused_rd_bits = ^bus_rdata[30:16];

    fps_geom u_geom (
        .mfr_id (id_q[7:0]),
        .dev_id (id_q[15:8]),
        .geom   (geom)
    );

    fps_poll #(.PW(PW)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (poll_en),
        .limit (poll_limit),
        .last  (poll_last)
    );

    fps_walk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (walk_load),
        .step     (walk_step),
        .base     (base_addr),
        .count    (word_count),
        .cur_addr (cur_addr),
        .idx      (word_idx),
        .at_end   (at_end)
    );

    assign ext_addr      = 24'(cur_addr);
    assign on_boundary   = ((ext_addr & geom.off_mask) == 24'h0);
    assign sec_sel       = (ext_addr & geom.sec_mask) << 2;
    assign erase_payload = {8'h00, erase_word(sec_sel)};

    // Next state and bus command for the current step.
    always_comb begin
        st_d       = st_q;
        bus_wr     = 1'b0;
        bus_rd     = 1'b0;
        bus_sel    = SEL_ADDR;
        bus_wdata  = '0;
        poll_en    = 1'b0;
        poll_limit = WR_LIM;
        walk_load  = 1'b0;
        walk_step  = 1'b0;
        id_cap     = 1'b0;
        id_to      = 1'b0;
        fin        = 1'b0;
        fin_st     = ST_OK;
        case (st_q)
            S_IDLE: begin
                if (start) begin
                    walk_load = 1'b1;
                    st_d      = S_ID_AW;
                end
            end
            S_ID_AW: begin
                bus_wr    = 1'b1;
                bus_wdata = ID_LOC;
                st_d      = S_ID_POLL;
            end
            S_ID_POLL: begin
                bus_rd     = 1'b1;
                poll_en    = 1'b1;
                poll_limit = RD_LIM;
                if (flag_in) begin
                    st_d = S_ID_RD;
                end else if (poll_last) begin
                    id_to = 1'b1;
                    st_d  = S_UP_DW;
                end
            end
            S_ID_RD: begin
                bus_rd  = 1'b1;
                bus_sel = SEL_DATA;
                id_cap  = 1'b1;
                st_d    = S_UP_DW;
            end
            S_UP_DW: begin
                bus_wr  = 1'b1;
                bus_sel = SEL_DATA;
                st_d    = S_UP_AW;
            end
            S_UP_AW: begin
                bus_wr    = 1'b1;
                bus_wdata = FLAG_MASK | CFG_MASK | 32'(UNPROT_LOC);
                st_d      = S_UP_POLL;
            end
            S_UP_POLL: begin
                bus_rd  = 1'b1;
                poll_en = 1'b1;
                if (!flag_in || poll_last) begin
                    st_d = S_NEXT;
                end
            end
            S_NEXT: begin
                if (at_end) begin
                    fin  = 1'b1;
                    st_d = S_DONE;
                end else if (on_boundary) begin
                    st_d = S_ER_DW;
                end else begin
                    st_d = S_PG_DW;
                end
            end
            S_ER_DW: begin
                bus_wr    = 1'b1;
                bus_sel   = SEL_DATA;
                bus_wdata = erase_payload;
                st_d      = S_ER_AW;
            end
            S_ER_AW: begin
                bus_wr    = 1'b1;
                bus_wdata = FLAG_MASK | CFG_MASK | 32'(geom.erase_loc);
                st_d      = S_ER_POLL;
            end
            S_ER_POLL: begin
                bus_rd  = 1'b1;
                poll_en = 1'b1;
                if (!flag_in) begin
                    st_d = S_PG_DW;
                end else if (poll_last) begin
                    fin    = 1'b1;
                    fin_st = ST_ERASE_FAIL;
                    st_d   = S_DONE;
                end
            end
            S_PG_DW: begin
                bus_wr    = 1'b1;
                bus_sel   = SEL_DATA;
                bus_wdata = src_data;
                st_d      = S_PG_AW;
            end
            S_PG_AW: begin
                bus_wr    = 1'b1;
                bus_wdata = FLAG_MASK | 32'(cur_addr);
                st_d      = S_PG_POLL;
            end
            S_PG_POLL: begin
                bus_rd  = 1'b1;
                poll_en = 1'b1;
                if (!flag_in) begin
                    walk_step = 1'b1;
                    st_d      = S_NEXT;
                end else if (poll_last) begin
                    fin    = 1'b1;
                    fin_st = ST_PROG_FAIL;
                    st_d   = S_DONE;
                end
            end
            S_DONE: begin
                st_d = S_IDLE;
            end
            default: begin
                st_d = S_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Capture the identification word, or the fallback on timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q <= '0;
        end else if (id_cap) begin
            id_q <= bus_rdata[15:0];
        end else if (id_to) begin
            id_q <= TIMEOUT_WORD[15:0];
        end
    end

    // Write enable: raised before unprotect, dropped on every exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q <= 1'b0;
        end else if (fin) begin
            wen_q <= 1'b0;
        end else if (st_d == S_UP_DW && st_q != S_UP_DW) begin
            wen_q <= 1'b1;
        end
    end

    // Hold the final status from the exit decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= ST_OK;
        end else if (fin) begin
            status_q <= fin_st;
        end
    end

    assign flash_wen = wen_q;
    assign done      = (st_q == S_DONE);
    assign status    = status_q;

    p_wen_off_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !flash_wen);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_flag_write_wen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == SEL_ADDR && bus_wdata[FLAG_BIT]) |-> flash_wen);

    p_no_write_after_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != 2'd0) |-> (!bus_wr && !bus_rd));

endmodule

// File: tb/flash_prog_seq_bench.sv
// Bench: behavioural flash register model plus an expected-write list built
// from the requirements; every clock's bus write is compared against it.
module flash_prog_seq_bench;

    localparam int AW  = 20;
    localparam int CW  = 8;
    localparam int RDP = 16;
    localparam int WRP = 32;
    localparam int LAT = 3;
    localparam int NEVER = 1000000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [CW-1:0] word_count = '0;
    logic [31:0]   src_data;
    logic [CW-1:0] word_idx;
    logic          bus_wr, bus_rd, bus_sel;
    logic [31:0]   bus_wdata, bus_rdata;
    logic          flash_wen, done;
    logic [1:0]    status;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #4 clk = ~clk;

    assign src_data = {8'hC3, word_idx, ~word_idx, 8'h5A};

    flash_prog_seq #(.ADDR_W(AW), .CNT_W(CW), .RD_POLLS(RDP), .WR_POLLS(WRP)) u_flash_prog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .word_count(word_count), .src_data(src_data), .word_idx(word_idx),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flash_wen(flash_wen), .done(done), .status(status)
    );

    // ---------------- flash register model ----------------
    logic [31:0] m_addr, m_data;
    logic        m_flag;
    int          m_busy;
    bit          m_rd_pending;
    int          m_kwr;
    int          m_stuck = -1;
    bit          m_silent = 1'b0;
    logic [31:0] m_id = '0;

    assign bus_rdata = bus_sel ? m_data : {m_flag, m_addr[30:0]};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr <= '0; m_data <= '0; m_flag <= 1'b0;
            m_busy <= 0; m_rd_pending <= 1'b0; m_kwr <= 0;
        end else begin
            if (m_busy == 1) begin
                if (m_rd_pending) begin
                    m_flag <= 1'b1;
                    m_data <= m_id;
                end else begin
                    m_flag <= 1'b0;
                end
            end
            if (m_busy > 0) m_busy <= m_busy - 1;
            if (bus_wr && bus_sel) m_data <= bus_wdata;
            if (bus_wr && !bus_sel) begin
                m_addr <= bus_wdata;
                if (bus_wdata[31]) begin
                    m_flag <= 1'b1;
                    m_rd_pending <= 1'b0;
                    m_busy <= (m_kwr == m_stuck) ? NEVER : LAT;
                    m_kwr <= m_kwr + 1;
                end else begin
                    m_flag <= 1'b0;
                    m_rd_pending <= 1'b1;
                    m_busy <= m_silent ? NEVER : LAT;
                end
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic        exp_sel[$];
    logic [31:0] exp_dat[$];
    string       exp_tag[$];

    function automatic void push(input logic s, input logic [31:0] d, input string t);
        exp_sel.push_back(s);
        exp_dat.push_back(d);
        exp_tag.push_back(t);
    endfunction

    int poll_run = 0;
    int id_run   = 0;
    bit seen_dw  = 1'b0;

    // Per-clock comparison of bus writes against the expected list.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_rd && !bus_sel) poll_run++;
            if (bus_wr) begin
                if (exp_sel.size() == 0) begin
                    chk(1'b0, "R8 extra write", bus_wdata, 32'h0);
                end else begin
                    chk(bus_sel == exp_sel[0] && bus_wdata == exp_dat[0],
                        exp_tag[0], bus_wdata, exp_dat[0]);
                    void'(exp_sel.pop_front());
                    void'(exp_dat.pop_front());
                    void'(exp_tag.pop_front());
                end
                if (!bus_sel && bus_wdata[31])
                    chk(flash_wen, "R6 wen during flagged write", 32'(flash_wen), 32'h1);
                if (bus_sel && !seen_dw) begin
                    id_run  = poll_run;
                    seen_dw = 1'b1;
                end
                poll_run = 0;
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // Build the expected write list and result from the requirements.
    task automatic build(input logic [7:0] mfr, input logic [7:0] dev, input int base,
                         input int cnt, input int stuck, input bit silent,
                         output int exp_st, output int exp_idx);
        logic [7:0]  m, d;
        logic [31:0] off, sec, eloc, a, s, pay;
        string       gtag;
        int          k;
        m = silent ? 8'hAD : mfr;
        d = silent ? 8'hDE : dev;
        if (m == 8'hbf) begin
            off = 32'h1fff; sec = 32'h3e000;
            eloc = (d == 8'h80) ? 32'h352 : 32'h3d8;
            gtag = "R3 erase command";
        end else begin
            off = 32'h3fff; sec = 32'h3c000; eloc = 32'h3d8;
            gtag = "R4 erase command";
        end
        push(1'b0, 32'h000d03ab, "R1 id address");
        push(1'b1, 32'h0, "R6 unprotect data");
        push(1'b0, 32'hC0000101, "R6 unprotect address");
        k = 1; exp_st = 0; exp_idx = cnt;
        for (int i = 0; i < cnt; i++) begin
            a = (base + i) & 32'hFFFFF;
            if ((a & off) == 0) begin
                s   = ((a & sec) << 2) & 32'hFFFFFF;
                pay = ((s & 32'hFF) << 16) | (s & 32'hFF00) | ((s >> 16) & 32'hFF);
                push(1'b1, pay, "R5 erase data");
                push(1'b0, 32'hC0000000 | eloc, gtag);
                if (k == stuck) begin exp_st = 1; exp_idx = i; break; end
                k++;
            end
            push(1'b1, {8'hC3, 8'(i), ~8'(i), 8'h5A}, "R7 program data");
            push(1'b0, 32'h80000000 | a, "R7 program address");
            if (k == stuck) begin exp_st = 2; exp_idx = i; break; end
            k++;
        end
    endtask

    task automatic run_case(input string name, input logic [7:0] mfr, input logic [7:0] dev,
                            input int base, input int cnt, input int stuck,
                            input bit silent, input bit restart);
        int exp_st, exp_idx, g;
        @(negedge clk);
        rst_n = 1'b0;
        exp_sel.delete(); exp_dat.delete(); exp_tag.delete();
        build(mfr, dev, base, cnt, stuck, silent, exp_st, exp_idx);
        m_id = {16'h0, dev, mfr};
        m_silent = silent;
        m_stuck = stuck;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        poll_run = 0; id_run = 0; seen_dw = 1'b0;
        @(negedge clk);
        base_addr = AW'(base); word_count = CW'(cnt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart) begin
            // R10: a second start with other values mid-run must be ignored
            repeat (4) @(negedge clk);
            base_addr = '0; word_count = 8'd1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        g = 0;
        while (!done && g < 5000) begin
            @(negedge clk);
            g++;
        end
        chk(done, {name, " R9 done seen"}, 32'(done), 32'h1);
        chk(status == 2'(exp_st), {name, " R8 status"}, 32'(status), 32'(exp_st));
        chk(word_idx == CW'(exp_idx), {name, " R9 word_idx"}, 32'(word_idx), 32'(exp_idx));
        chk(!flash_wen, {name, " R9 wen low at done"}, 32'(flash_wen), 32'h0);
        chk(exp_sel.size() == 0, {name, " R7 writes missing"}, 32'(exp_sel.size()), 32'h0);
        if (stuck >= 0)
            chk(poll_run == WRP, {name, " R8 poll count"}, 32'(poll_run), 32'(WRP));
        if (silent)
            chk(id_run == RDP, {name, " R2 id poll count"}, 32'(id_run), 32'(RDP));
        @(negedge clk);
        chk(!done, {name, " R9 single pulse"}, 32'(done), 32'h0);
        chk(!flash_wen, {name, " R9 wen stays low"}, 32'(flash_wen), 32'h0);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!done && !flash_wen && !bus_wr && !bus_rd, "R11 reset outputs",
            {28'h0, done, flash_wen, bus_wr, bus_rd}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !flash_wen && !bus_wr && !bus_rd, "R11 idle after reset",
            {28'h0, done, flash_wen, bus_wr, bus_rd}, 32'h0);

        run_case("small alt-dev R3 R10", 8'hbf, 8'h80, 32'h01ffe, 5, -1, 1'b0, 1'b1);
        run_case("small std-dev R3",     8'hbf, 8'h11, 32'h3dffe, 4, -1, 1'b0, 1'b0);
        run_case("mfr13 boundary R4",    8'h13, 8'h00, 32'h13ffe, 4, -1, 1'b0, 1'b0);
        run_case("mfr13 no-erase R4",    8'h13, 8'h00, 32'h11ffe, 3, -1, 1'b0, 1'b0);
        run_case("other first-word R5",  8'h20, 8'h00, 32'h00000, 3, -1, 1'b0, 1'b0);
        run_case("silent id R2",         8'hbf, 8'h80, 32'h01fff, 2, -1, 1'b1, 1'b0);
        run_case("program stuck R8",     8'h13, 8'h00, 32'h00100, 4,  3, 1'b0, 1'b0);
        run_case("erase stuck R8",       8'hbf, 8'h00, 32'h01ffe, 4,  3, 1'b0, 1'b0);
        run_case("zero count R9",        8'h13, 8'h00, 32'h00500, 0, -1, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule